// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16450/16550-style serial port reports. It receives the raw interrupt conditions from the rest of the UART and the four interrupt enable bits. From these it builds the interrupt identification byte that the host reads, and it drives the interrupt request line. The raw conditions are a line error, received data (or the receive FIFO reaching its trigger level), a character timeout, the transmit holding register becoming empty, and a modem status change. The data path, the FIFOs, the baud generator and the character timeout counter sit outside this block. They appear here only as strobes and level flags.

Each pending source has its own clearing side effect:
- The line error source clears when the line status register is read.
- The modem source clears when the modem status register is read.
- The transmit-empty source clears on a write to the holding register, or on an identification read that reports it.
- In character mode, the receive source clears on a receive buffer read. In FIFO mode it follows the trigger-level flag.

While an identification read is in progress, the byte it returns stays frozen. Events that arrive during the read are recorded and show up once the read ends. The request line reaches the pin only when the modem-control user output OUT2 is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, `iir_byte` reads 0x01 and `irq` is 0, even with every enable set.
- R2: Bit 0 of `iir_byte` is 0 exactly when some enabled source is active and 1 otherwise. `irq` is 1 only while bit 0 of the live byte is 0.
- R3: Bits 3..1 carry a fixed code for the winning source. The sources, from highest priority to lowest, are: line error 011 (byte 0x06); receive data 010 (0x04) or character timeout 110 (0x0C); transmit empty 001 (0x02); modem change 000 (0x00).
- R4: Receive data and character timeout share one priority level. When both are active, the receive code 010 is reported.
- R5: Bits 7:6 read 11 when `fifo_mode` is 1 and 00 otherwise. Bits 5:4 always read 0. `rx_tmo` is ignored when `fifo_mode` is 0, so bit 3 is 0 in character mode.
- R6: `ier_en` bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line error, and bit 3 enables modem change. A disabled source is not reported. Its pending state is kept and appears when the source is enabled.
- R7: Transmit empty clears on `thr_wr`, or on an identification read whose reported code is 001. An identification read that reports another code leaves it pending.
- R8: The line error source clears on `lsr_rd`. The modem change source clears on `msr_rd`.
- R9: In character mode, receive data is set by `rx_data_evt` and cleared by `rbr_rd`. In FIFO mode it follows the `rx_trig` level.
- R10: From the first cycle of an identification read (`iir_rd` high) until `iir_rd` falls, `iir_byte` holds the value it showed in that first cycle. Events arriving during the read are reported after it ends.
- R11: `irq` is 0 whenever `out2` is 0, even while a source is pending.
- R12: If a set strobe and a clear strobe hit the same source in one cycle, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_en | input | 4 | Interrupt enable bits |
| fifo_mode | input | 1 | FIFO mode active |
| out2 | input | 1 | Modem-control user output gating the request pin |
| ls_err_evt | input | 1 | Strobe: line error detected |
| lsr_rd | input | 1 | Strobe: line status register read |
| rx_data_evt | input | 1 | Strobe: character received (character mode) |
| rbr_rd | input | 1 | Strobe: receive buffer read |
| rx_trig | input | 1 | Level: receive FIFO at or above trigger |
| rx_tmo | input | 1 | Level: character timeout with data in FIFO |
| thre_evt | input | 1 | Strobe: transmit holding register became empty |
| thr_wr | input | 1 | Strobe: transmit holding register written |
| ms_chg_evt | input | 1 | Strobe: modem input changed |
| msr_rd | input | 1 | Strobe: modem status register read |
| iir_rd | input | 1 | Level: identification register read in progress |
| iir_byte | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request to the pin |

## Verification
The bench drives each source on its own and then stacks them, clearing them one at a time. This exposes a wrong priority order or a swapped code, which would show as the wrong byte after a clear. It checks that an identification read clears only the transmit-empty source it reports. A design that cleared on any read would lose the modem interrupt. A design that never cleared would leave 0x02 standing. It injects a line error in the middle of a read. A design without the freeze would change the byte mid-read, and one that dropped the event would never report 0x06. It also pulses a set and a clear together, which catches a latch that lets the clear win.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W    = 8;
    localparam int EN_W    = 4;
    localparam int CODE_W  = 3;

    // enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;

    // latched source indices
    localparam int LT_LS   = 0;
    localparam int LT_RX   = 1;
    localparam int LT_THRE = 2;
    localparam int LT_MS   = 3;
    localparam int N_LATCH = 4;

    typedef enum logic [CODE_W-1:0] {
        SRC_MS   = 3'b000,
        SRC_THRE = 3'b001,
        SRC_RX   = 3'b010,
        SRC_LS   = 3'b011,
        SRC_TMO  = 3'b110
    } irq_code_e;

    typedef struct packed {
        logic ls;
        logic rx;
        logic tmo;
        logic thre;
        logic ms;
    } irq_act_t;

    function automatic logic [ID_W-1:0] build_id(input logic pending,
                                                 input irq_code_e code,
                                                 input logic fifo);
        logic [ID_W-1:0] b;
        b      = '0;
        b[7:6] = {2{fifo}};
        b[3:1] = pending ? code : 3'b000;
        b[0]   = ~pending;
        return b;
    endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (clr_i[i]) q_o[i] <= 1'b0;
        end

        assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  irq_act_t        act_i,
    input  logic            fifo_mode_i,
    output irq_code_e       code_o,
    output logic            pending_o,
    output logic [ID_W-1:0] id_o
);
    always_comb begin
        pending_o = 1'b1;
        if (act_i.ls)        code_o = SRC_LS;
        else if (act_i.rx)   code_o = SRC_RX;
        else if (act_i.tmo)  code_o = SRC_TMO;
        else if (act_i.thre) code_o = SRC_THRE;
        else begin
            code_o    = SRC_MS;
            pending_o = act_i.ms;
        end
        id_o = build_id(pending_o, code_o, fifo_mode_i);
    end

    assert_ls_first_R3: assert property (@(posedge clk) disable iff (rst)
        act_i.ls |-> (id_o[3:1] == 3'b011) && !id_o[0]);

    assert_rx_over_tmo_R4: assert property (@(posedge clk) disable iff (rst)
        (act_i.rx && !act_i.ls) |-> (id_o[3:1] == 3'b010));

    assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (id_o[5:4] == 2'b00) && (id_o[7] == fifo_mode_i) && (id_o[3] -> fifo_mode_i));
endmodule

// File: rtl/uart_irq_freeze.sv
module uart_irq_freeze
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_i,
    input  logic [ID_W-1:0] live_i,
    output logic [ID_W-1:0] byte_o,
    output logic            take_o
);
    logic            hold;
    logic [ID_W-1:0] snap;

    assign take_o = rd_i && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b0;
            snap <= 8'h01;
        end else begin
            hold <= rd_i;
            if (take_o) snap <= live_i;
        end
    end

    assign byte_o = (rd_i && hold) ? snap : live_i;

    assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_i && $past(rd_i) && !$past(rst)) |-> $stable(byte_o));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EN_W-1:0] ier_en,
    input  logic            fifo_mode,
    input  logic            out2,
    input  logic            ls_err_evt,
    input  logic            lsr_rd,
    input  logic            rx_data_evt,
    input  logic            rbr_rd,
    input  logic            rx_trig,
    input  logic            rx_tmo,
    input  logic            thre_evt,
    input  logic            thr_wr,
    input  logic            ms_chg_evt,
    input  logic            msr_rd,
    input  logic            iir_rd,
    output logic [ID_W-1:0] iir_byte,
    output logic            irq
);
    logic [N_LATCH-1:0] set_v, clr_v, pend;
    irq_act_t           act;
    irq_code_e          code;
    logic               pending;
    logic [ID_W-1:0]    live_id;
    logic               take;
    logic               thre_rd_clr;

    assign thre_rd_clr = take && pending && (code == SRC_THRE);

    always_comb begin
        set_v          = '0;
        clr_v          = '0;
        set_v[LT_LS]   = ls_err_evt;
        clr_v[LT_LS]   = lsr_rd;
        set_v[LT_RX]   = rx_data_evt;
        clr_v[LT_RX]   = rbr_rd;
        set_v[LT_THRE] = thre_evt;
        clr_v[LT_THRE] = thr_wr || thre_rd_clr;
        set_v[LT_MS]   = ms_chg_evt;
        clr_v[LT_MS]   = msr_rd;
    end

    uart_irq_latch #(.N(N_LATCH)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (pend)
    );

    always_comb begin
        act.ls   = ier_en[EN_LS]   && pend[LT_LS];
        act.rx   = ier_en[EN_RX]   && (fifo_mode ? rx_trig : pend[LT_RX]);
        act.tmo  = ier_en[EN_RX]   && fifo_mode && rx_tmo;
        act.thre = ier_en[EN_THRE] && pend[LT_THRE];
        act.ms   = ier_en[EN_MS]   && pend[LT_MS];
    end

    uart_irq_prio u_prio (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .fifo_mode_i (fifo_mode),
        .code_o      (code),
        .pending_o   (pending),
        .id_o        (live_id)
    );

    uart_irq_freeze u_freeze (
        .clk    (clk),
        .rst    (rst),
        .rd_i   (iir_rd),
        .live_i (live_id),
        .byte_o (iir_byte),
        .take_o (take)
    );

    assign irq = out2 && pending;

    assert_out2_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !out2 |-> !irq);

    assert_irq_pending_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> !live_id[0]);

    assert_thre_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (take && live_id[3:0] == 4'b0010 && !thre_evt) |=> !pend[LT_THRE]);
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ier_en;
    logic       fifo_mode, out2, rx_trig, rx_tmo, iir_rd;
    // strobe bus: 0 ls_err_evt, 1 lsr_rd, 2 rx_data_evt, 3 rbr_rd,
    //             4 thre_evt, 5 thr_wr, 6 ms_chg_evt, 7 msr_rd
    logic [7:0] strb;
    logic [7:0] iir_byte;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    localparam logic [7:0] S_LSE = 8'h01, S_LSR = 8'h02, S_RXE = 8'h04, S_RBR = 8'h08,
                           S_THE = 8'h10, S_THW = 8'h20, S_MSE = 8'h40, S_MSR = 8'h80;

    always #2 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst(rst), .ier_en(ier_en), .fifo_mode(fifo_mode), .out2(out2),
        .ls_err_evt(strb[0]), .lsr_rd(strb[1]), .rx_data_evt(strb[2]), .rbr_rd(strb[3]),
        .rx_trig(rx_trig), .rx_tmo(rx_tmo), .thre_evt(strb[4]), .thr_wr(strb[5]),
        .ms_chg_evt(strb[6]), .msr_rd(strb[7]), .iir_rd(iir_rd),
        .iir_byte(iir_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk); strb = m;
        @(negedge clk); strb = '0; #1;
    endtask

    task automatic do_reset(input logic [3:0] en, input logic fm, input logic o2);
        @(negedge clk);
        rst = 1'b1; strb = '0; iir_rd = 1'b0; rx_trig = 1'b0; rx_tmo = 1'b0;
        ier_en = en; fifo_mode = fm; out2 = o2;
        repeat (2) @(negedge clk);
        rst = 1'b0; #1;
    endtask

    task automatic t_reset();
        do_reset(4'hF, 1'b0, 1'b1);
        chk("R1 byte", iir_byte, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_codes();
        do_reset(4'hF, 1'b0, 1'b1);
        pulse(S_MSE); chk("R3 modem", iir_byte, 8'h00);
        chk("R2 irq", {7'd0, irq}, 8'h01);
        pulse(S_THE); chk("R3 thre", iir_byte, 8'h02);
        pulse(S_RXE); chk("R3 rx", iir_byte, 8'h04);
        pulse(S_LSE); chk("R3 ls", iir_byte, 8'h06);
        pulse(S_LSR); chk("R8 ls clear", iir_byte, 8'h04);
        pulse(S_RBR); chk("R9 rbr clear", iir_byte, 8'h02);
        pulse(S_THW); chk("R7 thr write", iir_byte, 8'h00);
        pulse(S_MSR); chk("R8 ms clear", iir_byte, 8'h01);
        chk("R2 no irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_fifo();
        do_reset(4'h1, 1'b1, 1'b1);
        chk("R5 fifo idle", iir_byte, 8'hC1);
        rx_tmo = 1'b1; settle(); chk("R3 timeout", iir_byte, 8'hCC);
        rx_trig = 1'b1; settle(); chk("R4 rx over tmo", iir_byte, 8'hC4);
        rx_trig = 1'b0; settle(); chk("R9 trig level", iir_byte, 8'hCC);
        fifo_mode = 1'b0; settle(); chk("R5 tmo ignored", iir_byte, 8'h01);
    endtask

    task automatic t_enable();
        do_reset(4'h0, 1'b0, 1'b1);
        pulse(S_LSE | S_RXE | S_THE | S_MSE);
        chk("R6 all off", iir_byte, 8'h01);
        ier_en = 4'b1000; settle(); chk("R6 bit3 ms", iir_byte, 8'h00);
        ier_en = 4'b0100; settle(); chk("R6 bit2 ls", iir_byte, 8'h06);
        ier_en = 4'b0010; settle(); chk("R6 bit1 thre", iir_byte, 8'h02);
        ier_en = 4'b0001; settle(); chk("R6 bit0 rx", iir_byte, 8'h04);
    endtask

    task automatic t_thre_read();
        do_reset(4'hF, 1'b0, 1'b1);
        pulse(S_THE | S_MSE);
        @(negedge clk); iir_rd = 1'b1; #1;
        chk("R7 read sees thre", iir_byte, 8'h02);
        @(negedge clk); iir_rd = 1'b0; #1;
        chk("R7 cleared by read", iir_byte, 8'h00);
        @(negedge clk); iir_rd = 1'b1;
        @(negedge clk); iir_rd = 1'b0; #1;
        chk("R7 modem kept", iir_byte, 8'h00);
    endtask

    task automatic t_freeze();
        do_reset(4'hF, 1'b0, 1'b1);
        @(negedge clk); iir_rd = 1'b1; #1;
        chk("R10 start", iir_byte, 8'h01);
        @(negedge clk); strb = S_LSE;
        @(negedge clk); strb = '0; #1;
        chk("R10 frozen", iir_byte, 8'h01);
        chk("R10 irq live", {7'd0, irq}, 8'h01);
        @(negedge clk); iir_rd = 1'b0; #1;
        chk("R10 after read", iir_byte, 8'h06);
    endtask

    task automatic t_out2();
        do_reset(4'hF, 1'b0, 1'b0);
        pulse(S_MSE);
        chk("R11 gated irq", {7'd0, irq}, 8'h00);
        chk("R11 byte", iir_byte, 8'h00);
        out2 = 1'b1; settle();
        chk("R11 ungated irq", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_setwins();
        do_reset(4'hF, 1'b0, 1'b1);
        pulse(S_LSE);
        pulse(S_LSE | S_LSR); chk("R12 ls", iir_byte, 8'h06);
        pulse(S_LSR);
        pulse(S_THE | S_THW); chk("R12 thre", iir_byte, 8'h02);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; strb = '0; iir_rd = 1'b0; rx_trig = 1'b0; rx_tmo = 1'b0;
        ier_en = '0; fifo_mode = 1'b0; out2 = 1'b0;
        t_reset();
        t_codes();
        t_fifo();
        t_enable();
        t_thre_read();
        t_freeze();
        t_out2();
        t_setwins();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule